// File: doc/BRIEF.md
# Pixel-to-Sample Index Calculator

This block turns an image pixel and the current radar pulse position into the sample address that pixel needs in the stored return of that pulse. All coordinates are already scaled so that one range sample is one unit. The block forms the straight-line distance from the radar to the pixel as the integer square root of the squared along-track offset plus the squared cross-track range. It then subtracts the first range sample kept for this strip of the image and gives the result as an 11-bit address into a 2048-entry sample memory.

Beside the distance path, a beam test decides whether the pixel lies inside the antenna footprint for this pulse. The test compares the absolute along-track offset with the range multiplied by a fixed-point cone constant, which the host computes once from the fixed beam angle. A pixel outside the beam, or one whose address falls outside the memory, leaves with its flag low and a zero address. Downstream logic uses that flag to feed zero into the accumulator. The path accepts one pixel per clock. Every result leaves together with its flag and valid bit after a fixed latency.

Top module: `beam_index_calc`

## Requirements
- R1: With a pixel presented with `inValid` high before rising edge E, `outValid` and the result for that pixel appear after rising edge E+15, which is 16 edges counting E. A pixel given on every clock yields a result on every clock, in input order.
- R2: When the flag is high, `sampleIdx` equals floor(sqrt(d*d + r*r)) - `minRange`, where d = `pixAz` - `projAz` (signed) and r = `pixRange`.
- R3: The root is exact for perfect squares and rounds down for all other values, including the largest operands (both offsets 4095).
- R4: The beam test passes when |d| * 256 <= `beamConst` * r. `beamConst` is unsigned with 8 fractional bits, so 0x0100 means 1.0. Equality passes, and a failed test clears `inBeam`.
- R5: When the root is below `minRange`, `inBeam` is low.
- R6: When the root minus `minRange` is 2048 or more, `inBeam` is low.
- R7: Whenever `inBeam` is low, `sampleIdx` is 0.
- R8: After reset, `outValid` and `inBeam` are low and `sampleIdx` is 0.
- R9: An input cycle with `inValid` low produces a cycle with `outValid`, `inBeam` low and `sampleIdx` 0 at the matching output slot.
- R10: `projAz`, `minRange` and `beamConst` are taken with each pixel in the same cycle as `inValid`, so values that change on every clock apply to each pixel separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Pixel present this cycle |
| pixAz | input | 12 | Pixel along-track coordinate, sample units |
| pixRange | input | 12 | Pixel cross-track range from the flight line, sample units |
| projAz | input | 12 | Along-track position of the current pulse |
| minRange | input | 13 | First range sample held for this strip |
| beamConst | input | 16 | Beam cone factor, unsigned, 8 fractional bits |
| outValid | output | 1 | Result present this cycle |
| sampleIdx | output | 11 | Sample memory address, 0 when not in beam |
| inBeam | output | 1 | Pixel contributes for this pulse |

## Verification
On every cycle, the assertions check three things: no result emerges before the pipeline could have filled, idle and rejected slots leave a zero address with the flag low, and the remainder left by the last root stage is no greater than twice the root. That last property is what makes the root a floor square root. Only the bench scenarios can show that each address equals the expected distance minus the offset. They also show the edge cases of the beam comparison at exact equality, the rejection of addresses on both sides of the memory window, the 16-edge timing under bubbles, and the per-pixel capture of changing host constants.

// File: rtl/beam_index_pkg.sv
package beam_index_pkg;

  // Strobes the control sends to the datapath, one per non-root stage.
  typedef struct packed {
    logic frontLoad;   // capture pixel and host constants
    logic sumLoad;     // capture squared sum and beam decision
    logic finalLoad;   // capture index and flag
  } stageStrobes_t;

endpackage

// File: rtl/beam_index_ctrl.sv
module beam_index_ctrl
  import beam_index_pkg::*;
#(
  parameter int ROOT_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output stageStrobes_t     strobes,
  output logic [ROOT_W-1:0] rootLoad,
  output logic              outValid
);

  localparam int PIPE_LEN = ROOT_W + 3;
  localparam int CNT_W    = $clog2(PIPE_LEN + 1);

  logic [PIPE_LEN-1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[PIPE_LEN-2:0], inValid};
  end

  always_comb begin
    strobes.frontLoad = inValid;
    strobes.sumLoad   = validPipe[0];
    strobes.finalLoad = validPipe[ROOT_W+1];
  end

  assign rootLoad = validPipe[ROOT_W:1];
  assign outValid = validPipe[ROOT_W+2];

  // Cycles since reset, saturating; used only by the fill check below.
  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                      fillCnt <= '0;
    else if (fillCnt != CNT_W'(PIPE_LEN)) fillCnt <= fillCnt + 1'b1;
  end

  // R1: a result can only appear once a pixel has crossed every stage.
  assert_fill_before_output_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (fillCnt == CNT_W'(PIPE_LEN)));

endmodule

// File: rtl/beam_index_dp.sv
module beam_index_dp
  import beam_index_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int CONST_W    = 16,
  parameter int CONST_FRAC = 8,
  parameter int IDX_W      = 11
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stageStrobes_t          strobes,
  input  logic [COORD_W:0]       rootLoad,
  input  logic [COORD_W-1:0]     pixAz,
  input  logic [COORD_W-1:0]     pixRange,
  input  logic [COORD_W-1:0]     projAz,
  input  logic [COORD_W:0]       minRange,
  input  logic [CONST_W-1:0]     beamConst,
  output logic [IDX_W-1:0]       sampleIdx,
  output logic                   inBeam
);

  localparam int ROOT_W = COORD_W + 1;
  localparam int SUM_W  = 2 * COORD_W + 1;
  localparam int RAD_W  = 2 * ROOT_W;
  localparam int REM_W  = ROOT_W + 1;
  localparam int CMP_W  = COORD_W + CONST_W;

  // ---------------- stage 1: offsets and constant capture ----------------
  logic [COORD_W-1:0] absAz;
  assign absAz = (pixAz >= projAz) ? (pixAz - projAz) : (projAz - pixAz);

  logic [COORD_W-1:0] s1AbsAz, s1Rng;
  logic [CONST_W-1:0] s1Beam;
  logic [ROOT_W-1:0]  s1Min;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1AbsAz <= '0; s1Rng <= '0; s1Beam <= '0; s1Min <= '0;
    end else if (strobes.frontLoad) begin
      s1AbsAz <= absAz;
      s1Rng   <= pixRange;
      s1Beam  <= beamConst;
      s1Min   <= minRange;
    end
  end

  // ---------------- stage 2: squares, sum and beam test ----------------
  logic [2*COORD_W-1:0] sqAz, sqRng;
  logic [SUM_W-1:0]     sumNext;
  logic [CMP_W-1:0]     beamLhs, beamRhs;

  assign sqAz    = s1AbsAz * s1AbsAz;
  assign sqRng   = s1Rng * s1Rng;
  assign sumNext = {1'b0, sqAz} + {1'b0, sqRng};
  assign beamLhs = CMP_W'({s1AbsAz, {CONST_FRAC{1'b0}}});
  assign beamRhs = s1Beam * s1Rng;

  logic [SUM_W-1:0]  s2Sum;
  logic              s2BeamOk;
  logic [ROOT_W-1:0] s2Min;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2Sum <= '0; s2BeamOk <= 1'b0; s2Min <= '0;
    end else if (strobes.sumLoad) begin
      s2Sum    <= sumNext;
      s2BeamOk <= (beamLhs <= beamRhs);
      s2Min    <= s1Min;
    end
  end

  // ---------------- square root: one result bit per stage ----------------
  genvar i;
  generate
    for (i = 0; i < ROOT_W; i++) begin : stg
      localparam int RIN = RAD_W - 2 * i;

      logic [RIN-1:0]    radIn;
      logic [REM_W-1:0]  remIn;
      logic [ROOT_W-1:0] rootIn;
      logic              okIn;
      logic [ROOT_W-1:0] minIn;

      if (i == 0) begin : head
        assign radIn  = RIN'(s2Sum);
        assign remIn  = '0;
        assign rootIn = '0;
        assign okIn   = s2BeamOk;
        assign minIn  = s2Min;
      end else begin : link
        assign radIn  = stg[i-1].keep.radQ;
        assign remIn  = stg[i-1].remQ;
        assign rootIn = stg[i-1].rootQ;
        assign okIn   = stg[i-1].okQ;
        assign minIn  = stg[i-1].minQ;
      end

      logic [REM_W+1:0] remShift, trial, remNext;
      logic             takeBit;

      assign remShift = {remIn, radIn[RIN-1 -: 2]};
      assign trial    = (REM_W+2)'({rootIn, 2'b01});
      assign takeBit  = (remShift >= trial);
      assign remNext  = takeBit ? (remShift - trial) : remShift;

      logic [REM_W-1:0]  remQ;
      logic [ROOT_W-1:0] rootQ;
      logic              okQ;
      logic [ROOT_W-1:0] minQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          remQ <= '0; rootQ <= '0; okQ <= 1'b0; minQ <= '0;
        end else if (rootLoad[i]) begin
          remQ  <= remNext[REM_W-1:0];
          rootQ <= {rootIn[ROOT_W-2:0], takeBit};
          okQ   <= okIn;
          minQ  <= minIn;
        end
      end

      if (i < ROOT_W - 1) begin : keep
        logic [RIN-3:0] radQ;
        always_ff @(posedge clk) begin
          if (!rstN)              radQ <= '0;
          else if (rootLoad[i])   radQ <= radIn[RIN-3:0];
        end
      end
    end
  endgenerate

  logic [ROOT_W-1:0] rootF, minF;
  logic [REM_W-1:0]  remF;
  logic              okF;

  assign rootF = stg[ROOT_W-1].rootQ;
  assign minF  = stg[ROOT_W-1].minQ;
  assign remF  = stg[ROOT_W-1].remQ;
  assign okF   = stg[ROOT_W-1].okQ;

  // R3: the remainder never exceeds twice the root, so the root is the floor.
  assert_root_remainder_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finalLoad |-> (remF <= {rootF, 1'b0}));

  // ---------------- final stage: offset, window and flag ----------------
  logic [ROOT_W:0]   idxDiff;
  logic              inWindow, keepPix;

  assign idxDiff  = {1'b0, rootF} - {1'b0, minF};
  assign inWindow = !idxDiff[ROOT_W] && ((idxDiff[ROOT_W-1:0] >> IDX_W) == '0);
  assign keepPix  = okF && inWindow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBeam    <= 1'b0;
      sampleIdx <= '0;
    end else if (strobes.finalLoad) begin
      inBeam    <= keepPix;
      sampleIdx <= keepPix ? idxDiff[IDX_W-1:0] : '0;
    end else begin
      inBeam    <= 1'b0;
      sampleIdx <= '0;
    end
  end

  // R9: an empty slot leaves the block with a clear flag and a zero address.
  assert_idle_slot_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finalLoad |=> (!inBeam && sampleIdx == '0));

  // R7: a rejected pixel never carries a non-zero address.
  assert_reject_zero_index_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inBeam |-> (sampleIdx == '0));

endmodule

// File: rtl/beam_index_calc.sv
module beam_index_calc
  import beam_index_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int CONST_W    = 16,
  parameter int CONST_FRAC = 8,
  parameter int IDX_W      = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [COORD_W-1:0]   pixAz,
  input  logic [COORD_W-1:0]   pixRange,
  input  logic [COORD_W-1:0]   projAz,
  input  logic [COORD_W:0]     minRange,
  input  logic [CONST_W-1:0]   beamConst,
  output logic                 outValid,
  output logic [IDX_W-1:0]     sampleIdx,
  output logic                 inBeam
);

  localparam int ROOT_W = COORD_W + 1;

  stageStrobes_t     strobes;
  logic [ROOT_W-1:0] rootLoad;

  beam_index_ctrl #(.ROOT_W(ROOT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .rootLoad (rootLoad),
    .outValid (outValid)
  );

  beam_index_dp #(
    .COORD_W    (COORD_W),
    .CONST_W    (CONST_W),
    .CONST_FRAC (CONST_FRAC),
    .IDX_W      (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rootLoad  (rootLoad),
    .pixAz     (pixAz),
    .pixRange  (pixRange),
    .projAz    (projAz),
    .minRange  (minRange),
    .beamConst (beamConst),
    .sampleIdx (sampleIdx),
    .inBeam    (inBeam)
  );

  // R8: the outputs come out of reset idle.
  assert_reset_idle_R8: assert property (@(posedge clk)
    !rstN |=> (!outValid && !inBeam && sampleIdx == '0));

endmodule

// File: tb/tb_beam_index_calc.sv
module tb_beam_index_calc;

  localparam int LAT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] pixAz = '0, pixRange = '0, projAz = '0;
  logic [12:0] minRange = '0;
  logic [15:0] beamConst = '0;
  logic        outValid, inBeam;
  logic [10:0] sampleIdx;

  beam_index_calc dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .pixAz(pixAz),
    .pixRange(pixRange), .projAz(projAz), .minRange(minRange),
    .beamConst(beamConst), .outValid(outValid), .sampleIdx(sampleIdx),
    .inBeam(inBeam)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    bit    flag;
    int    idx;
    string req;
  } expect_t;
  expect_t q[$];

  function automatic longint isqrt(longint n);
    longint r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Drive one pixel (or a bubble) at the falling edge and record its expectation.
  task automatic drive(bit v, int az, int rg, int pa, int mn, int bc, string req);
    expect_t e;
    longint d, s, root, diff;
    bit beamOk;
    @(negedge clk);
    inValid = v; pixAz = 12'(az); pixRange = 12'(rg); projAz = 12'(pa);
    minRange = 13'(mn); beamConst = 16'(bc);
    d = longint'(az) - longint'(pa);
    if (d < 0) d = -d;
    s = d * d + longint'(rg) * longint'(rg);
    root = isqrt(s);
    beamOk = (d * 256) <= (longint'(bc) * longint'(rg));
    diff = root - mn;
    e.due = cyc + LAT;
    e.flag = v && beamOk && diff >= 0 && diff < 2048;
    e.idx = e.flag ? int'(diff) : 0;
    if (!v) e.req = "R9";
    else if (req != "") e.req = req;
    else if (!beamOk) e.req = "R4";
    else if (diff < 0) e.req = "R5";
    else if (diff >= 2048) e.req = "R6";
    else e.req = "R2";
    q.push_back(e);
  endtask

  // Compare every output slot against the head of the expectation queue.
  always @(negedge clk) begin
    if (rstN && q.size() > 0 && q[0].due == cyc) begin
      expect_t e;
      e = q.pop_front();
      check(outValid == (e.req != "R9"), "R1", "outValid", int'(outValid), int'(e.req != "R9"));
      check(inBeam == e.flag, e.req, "inBeam", int'(inBeam), int'(e.flag));
      if (!e.flag)
        check(sampleIdx == 0, "R7", "sampleIdx", int'(sampleIdx), 0);
      else
        check(int'(sampleIdx) == e.idx, e.req, "sampleIdx", int'(sampleIdx), e.idx);
    end else if (rstN && outValid) begin
      check(1'b0, "R1", "unexpected outValid", 1, 0);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!outValid && !inBeam && sampleIdx == 0, "R8", "reset outputs",
          int'(outValid) + int'(inBeam) + int'(sampleIdx), 0);
    rstN = 1'b1;

    // Directed corners
    drive(1, 300, 400, 0, 100, 'h0100, "R2");      // 3-4-5 -> 500-100
    drive(1, 0, 400, 300, 100, 'h0100, "R2");      // negative offset
    drive(1, 400, 400, 0, 0, 'h0100, "R4");        // beam equality passes
    drive(1, 401, 400, 0, 0, 'h0100, "R4");        // just outside beam
    drive(1, 4095, 4095, 0, 4000, 'h0100, "R3");   // largest operands, 5791
    drive(1, 0, 3000, 0, 0, 'h0100, "R3");         // exact square
    drive(1, 1, 2000, 0, 0, 'h0400, "R3");         // just above a square
    drive(1, 0, 10, 0, 11, 'h0100, "R5");          // index -1
    drive(1, 0, 10, 0, 10, 'h0100, "R5");          // index 0 accepted
    drive(1, 0, 2148, 0, 100, 'h0100, "R6");       // index 2048
    drive(1, 0, 2147, 0, 100, 'h0100, "R6");       // index 2047
    drive(0, 0, 500, 0, 0, 'h0100, "");            // bubble
    drive(1, 0, 0, 0, 0, 'h0000, "R4");            // zero range, zero offset
    drive(0, 7, 7, 7, 7, 7, "");
    drive(0, 7, 7, 7, 7, 7, "");

    // Host constants changing on every pixel
    for (int k = 0; k < 40; k++)
      drive(1, 1000 + k, 700, 1000 + 3 * k, k * 5, 'h0040 + 16 * k, "R10");

    // Random traffic with occasional bubbles
    for (int k = 0; k < 600; k++) begin
      bit v = ($urandom % 8) != 0;
      drive(v, $urandom % 4096, $urandom % 4096, $urandom % 4096,
            $urandom % 3000, $urandom % 1024, "");
    end

    @(negedge clk);
    inValid = 1'b0;
    repeat (LAT + 4) @(negedge clk);
    check(q.size() == 0, "R1", "results outstanding", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule